// File: doc/BRIEF.md
# Flash Block Protection Controller

This controller holds one protection flag for every block of a flash array, where a block is picked by a 7-bit block number. Equipment that programs the part sets the flags one block at a time. It can also clear all of them in a single timed operation. The raised-voltage pin conditions of the part are modelled here as plain digital mode inputs. A falling edge on the active-low write strobe `wr_n` starts whichever operation the mode inputs select.

During normal operation the controller sits between the command logic and the array sequencer. Every program or erase request passes through it. A request aimed at a protected block is accepted and then discarded. A request aimed at an open block is passed on. A temporary-override input opens all protected blocks for as long as it is held. When it is released, the stored flags apply again, unchanged.

A status query returns a byte for one block: 01h means protected and 00h means open. The query answers the same way in every mode, so normal-mode reads and programming-equipment verify reads use one path. Both request streams are valid/ready:
- **Program/erase:** `req_ready` is low while the controller is busy. Otherwise a blocked request is taken at once, and a request that is passed on waits for `fwd_ready`.
- **Status:** `stat_data` holds still while `stat_valid` is high and `stat_ready` is low. A new query is taken only when the output slot is empty or is being drained in that cycle.

Top module: `blk_guard_ctrl`

## Requirements
- R1: After reset, `busy` and `stat_valid` are 0 and every protection flag equals the `RESET_BITS` parameter (bit n belongs to block n; the default is all open).
- R2: A status query accepted on `vfy_valid && vfy_ready` gives `stat_valid` = 1 in the next cycle. The byte is 8'h01 if block `vfy_blk` is protected and 8'h00 if it is open. `vfy_ready` = `!stat_valid || stat_ready`, and `stat_data` stays stable while it is waiting.
- R3: A falling edge of `wr_n` with `mode_prot`=1 and `mode_unprot`=0 sets only the flag of block `blk_addr`. The change is visible to a query issued in the following cycle.
- R4: A falling edge of `wr_n` with `mode_unprot`=1, `mode_prot`=0 and every flag set raises `busy` for exactly DELAY_CYC = CLK_KHZ*DELAY_MS cycles. When `busy` falls, all flags are cleared at once.
- R5: An unprotect strobe while at least one block is open is refused: `busy` stays 0 and no flag changes.
- R6: While `busy` is 1, strobes are ignored (a second unprotect strobe does not lengthen the busy window), `req_ready` is 0 and `fwd_valid` is 0.
- R7: A program/erase request (`req_erase`: 1 = erase, 0 = program) to a protected block has `req_ready`=1 and `fwd_valid`=0. A request to an open block has `fwd_valid`=1 with the same `fwd_blk`/`fwd_erase`, and `req_ready` follows `fwd_ready`.
- R8: While `temp_unlock`=1, requests to protected blocks are forwarded and status queries still report the stored flags. After release, those blocks block requests again.
- R9: A strobe with `mode_prot` and `mode_unprot` both at 1 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_prot | input | 1 | Protect mode selected |
| mode_unprot | input | 1 | Unprotect-all mode selected |
| temp_unlock | input | 1 | Temporary override of protection |
| wr_n | input | 1 | Write strobe, active low; its falling edge starts an operation |
| blk_addr | input | 7 | Block number for a protect strobe |
| busy | output | 1 | Timed unprotect in progress |
| req_valid | input | 1 | Program/erase request valid |
| req_ready | output | 1 | Program/erase request accepted |
| req_erase | input | 1 | 1 = erase, 0 = program |
| req_blk | input | 7 | Target block of the request |
| fwd_valid | output | 1 | Allowed request toward the array |
| fwd_ready | input | 1 | Array side accepts the request |
| fwd_erase | output | 1 | Forwarded operation kind |
| fwd_blk | output | 7 | Forwarded target block |
| vfy_valid | input | 1 | Status query valid |
| vfy_ready | output | 1 | Status query accepted |
| vfy_blk | input | 7 | Block to query |
| stat_valid | output | 1 | Status byte valid |
| stat_ready | input | 1 | Consumer takes the status byte |
| stat_data | output | 8 | 01h protected, 00h open |

## Verification
Status queries are run against a block that was just protected and against both of its neighbours. This shows whether a protect strobe reaches only the addressed flag. Unprotect strobes are tried with one block still open and again with all blocks set, which tells the refusal case from the timed clear. A second strobe is sent during the busy window to show that the window is fixed. Program and erase requests are sent to protected and open blocks, with the override on and off and with the array side stalled. This separates dropping, forwarding and back-pressure, and shows that the override leaves the stored flags intact.

// File: rtl/blk_guard_pkg.sv
package blk_guard_pkg;
  typedef enum logic [1:0] {
    STB_NONE   = 2'd0,
    STB_PROT   = 2'd1,
    STB_UNPROT = 2'd2
  } stb_kind_e;

  localparam logic [7:0] ST_PROT = 8'h01;
  localparam logic [7:0] ST_OPEN = 8'h00;
endpackage

// File: rtl/blk_guard_bits.sv
module blk_guard_bits #(
  parameter int BLK_AW = 7,
  parameter logic [(1<<BLK_AW)-1:0] RESET_BITS = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     set_en,
  input  logic [BLK_AW-1:0]        set_blk,
  input  logic                     clr_all,
  output logic [(1<<BLK_AW)-1:0]   bits
);
  localparam int NUM_BLK = 1 << BLK_AW;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits <= RESET_BITS;
    end else if (clr_all) begin
      bits <= '0;
    end else if (set_en) begin
      bits[set_blk] <= 1'b1;
    end
  end

  AST_PROT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(set_en) && !$past(clr_all) |->
      bits == ($past(bits) | (NUM_BLK'(1) << $past(set_blk)))) else $error("AST_PROT_SINGLE"); // R3
endmodule

// File: rtl/blk_guard_timer.sv
module blk_guard_timer #(
  parameter int DELAY_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(DELAY_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= CW'(DELAY_CYC - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && (cnt != '0) |-> cnt == $past(cnt) - 1'b1) else $error("AST_NO_RESTART"); // R6
endmodule

// File: rtl/blk_guard_gate.sv
module blk_guard_gate #(
  parameter int BLK_AW = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [(1<<BLK_AW)-1:0] bits,
  input  logic                   busy,
  input  logic                   temp_unlock,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_erase,
  input  logic [BLK_AW-1:0]      req_blk,
  output logic                   fwd_valid,
  input  logic                   fwd_ready,
  output logic                   fwd_erase,
  output logic [BLK_AW-1:0]      fwd_blk
);
  logic blocked;

  assign blocked   = bits[req_blk] && !temp_unlock;
  assign fwd_valid = req_valid && !busy && !blocked;
  assign req_ready = !busy && (blocked || fwd_ready);
  assign fwd_erase = req_erase;
  assign fwd_blk   = req_blk;

  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready && !fwd_valid) else $error("AST_BUSY_STALL"); // R6
  AST_DROP_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !fwd_valid |-> bits[req_blk] && !temp_unlock) else $error("AST_DROP_ONLY_LOCKED"); // R7
endmodule

// File: rtl/blk_guard_status.sv
module blk_guard_status #(
  parameter int BLK_AW = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [(1<<BLK_AW)-1:0] bits,
  input  logic                   vfy_valid,
  output logic                   vfy_ready,
  input  logic [BLK_AW-1:0]      vfy_blk,
  output logic                   stat_valid,
  input  logic                   stat_ready,
  output logic [7:0]             stat_data
);
  import blk_guard_pkg::*;

  assign vfy_ready = !stat_valid || stat_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_valid <= 1'b0;
      stat_data  <= ST_OPEN;
    end else if (vfy_valid && vfy_ready) begin
      stat_valid <= 1'b1;
      stat_data  <= bits[vfy_blk] ? ST_PROT : ST_OPEN;
    end else if (stat_ready) begin
      stat_valid <= 1'b0;
    end
  end

  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && !stat_ready |=> stat_valid && $stable(stat_data)) else $error("AST_STAT_HOLD"); // R2
endmodule

// File: rtl/blk_guard_ctrl.sv
module blk_guard_ctrl #(
  parameter int BLK_AW   = 7,
  parameter int CLK_KHZ  = 250000,
  parameter int DELAY_MS = 10,
  parameter logic [(1<<BLK_AW)-1:0] RESET_BITS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_prot,
  input  logic              mode_unprot,
  input  logic              temp_unlock,
  input  logic              wr_n,
  input  logic [BLK_AW-1:0] blk_addr,
  output logic              busy,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_erase,
  input  logic [BLK_AW-1:0] req_blk,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic              fwd_erase,
  output logic [BLK_AW-1:0] fwd_blk,
  input  logic              vfy_valid,
  output logic              vfy_ready,
  input  logic [BLK_AW-1:0] vfy_blk,
  output logic              stat_valid,
  input  logic              stat_ready,
  output logic [7:0]        stat_data
);
  import blk_guard_pkg::*;

  localparam int NUM_BLK   = 1 << BLK_AW;
  localparam int DELAY_CYC = CLK_KHZ * DELAY_MS;

  logic               wr_q;
  logic               wr_fall;
  stb_kind_e          stb_kind;
  logic [NUM_BLK-1:0] bits;
  logic               clr_all;
  logic               unprot_go;

  always_ff @(posedge clk) begin
    if (!rst_n) wr_q <= 1'b1;
    else        wr_q <= wr_n;
  end

  assign wr_fall = wr_q && !wr_n;

  always_comb begin
    stb_kind = STB_NONE;
    if (wr_fall && !busy) begin
      if (mode_prot && !mode_unprot)      stb_kind = STB_PROT;
      else if (mode_unprot && !mode_prot) stb_kind = STB_UNPROT;
    end
  end

  assign unprot_go = (stb_kind == STB_UNPROT) && (&bits);

  blk_guard_bits #(.BLK_AW(BLK_AW), .RESET_BITS(RESET_BITS)) u_bits (
    .clk(clk), .rst_n(rst_n),
    .set_en(stb_kind == STB_PROT), .set_blk(blk_addr),
    .clr_all(clr_all), .bits(bits)
  );

  blk_guard_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(unprot_go),
    .busy(busy), .done(clr_all)
  );

  blk_guard_gate #(.BLK_AW(BLK_AW)) u_gate (
    .clk(clk), .rst_n(rst_n), .bits(bits), .busy(busy),
    .temp_unlock(temp_unlock),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_erase(req_erase), .req_blk(req_blk),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
    .fwd_erase(fwd_erase), .fwd_blk(fwd_blk)
  );

  blk_guard_status #(.BLK_AW(BLK_AW)) u_status (
    .clk(clk), .rst_n(rst_n), .bits(bits),
    .vfy_valid(vfy_valid), .vfy_ready(vfy_ready), .vfy_blk(vfy_blk),
    .stat_valid(stat_valid), .stat_ready(stat_ready), .stat_data(stat_data)
  );

  AST_UNPROT_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(&bits)) else $error("AST_UNPROT_NEEDS_ALL"); // R5
  AST_CLEAR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> bits == '0) else $error("AST_CLEAR_AT_END"); // R4
  AST_BOTH_MODES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fall && mode_prot && mode_unprot |=> $stable(bits) && !$rose(busy)) else $error("AST_BOTH_MODES_IDLE"); // R9
endmodule

// File: tb/blk_guard_ctrl_bench.sv
module blk_guard_ctrl_bench;
  localparam int AW = 7;
  localparam int KHZ = 2;
  localparam int MS = 10;
  localparam int DCYC = KHZ * MS;

  logic clk = 0, rst_n = 0;
  logic mode_prot = 0, mode_unprot = 0, temp_unlock = 0, wr_n = 1;
  logic [AW-1:0] blk_addr = '0, req_blk = '0, vfy_blk = '0;
  logic req_valid = 0, req_erase = 0, fwd_ready = 1, vfy_valid = 0, stat_ready = 1;
  logic busy, req_ready, fwd_valid, fwd_erase, vfy_ready, stat_valid;
  logic [AW-1:0] fwd_blk;
  logic [7:0] stat_data;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  blk_guard_ctrl #(.BLK_AW(AW), .CLK_KHZ(KHZ), .DELAY_MS(MS)) u_blk_guard_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_prot(mode_prot), .mode_unprot(mode_unprot),
    .temp_unlock(temp_unlock), .wr_n(wr_n), .blk_addr(blk_addr), .busy(busy),
    .req_valid(req_valid), .req_ready(req_ready), .req_erase(req_erase), .req_blk(req_blk),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_erase(fwd_erase), .fwd_blk(fwd_blk),
    .vfy_valid(vfy_valid), .vfy_ready(vfy_ready), .vfy_blk(vfy_blk),
    .stat_valid(stat_valid), .stat_ready(stat_ready), .stat_data(stat_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops expected status bytes as the design delivers them
  always @(negedge clk) begin
    if (rst_n && stat_valid && stat_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected status actual %0h expected none", stat_data);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        if (stat_data !== e) begin
          errors++;
          $display("FAIL R2 status byte actual %0h expected %0h", stat_data, e);
        end
      end
    end
  end

  // driver: issue a query, push the expected byte
  task automatic query(input int blk, input logic [7:0] exp);
    @(posedge clk); #1;
    vfy_valid = 1; vfy_blk = AW'(blk);
    exp_q.push_back(exp);
    @(negedge clk);
    while (!vfy_ready) @(negedge clk);
    @(posedge clk); #1;
    vfy_valid = 0;
  endtask

  task automatic strobe(input logic pm, input logic um, input int blk);
    @(posedge clk); #1;
    mode_prot = pm; mode_unprot = um; blk_addr = AW'(blk); wr_n = 0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    wr_n = 1; mode_prot = 0; mode_unprot = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 stat_valid", stat_valid, 0);
    query(0, 8'h00);    // R1 reset flags open
    query(127, 8'h00);  // R1

    // R3 protect one block
    strobe(1, 0, 5);
    query(5, 8'h01);
    query(4, 8'h00);
    query(6, 8'h00);

    // R9 both modes: no effect
    strobe(1, 1, 9);
    query(9, 8'h00);
    @(negedge clk); chk("R9 busy", busy, 0);

    // R5 refusal: some blocks open
    strobe(0, 1, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk("R5 busy stays low", busy, 0);
    end
    query(5, 8'h01);  // R5 flags unchanged

    // R7 gating
    @(posedge clk); #1;
    req_valid = 1; req_blk = 5; req_erase = 1; fwd_ready = 1;
    @(negedge clk);
    chk("R7 drop fwd_valid", fwd_valid, 0);
    chk("R7 drop ready", req_ready, 1);
    @(posedge clk); #1; req_blk = 4; req_erase = 0;
    @(negedge clk);
    chk("R7 pass fwd_valid", fwd_valid, 1);
    chk("R7 pass fwd_blk", fwd_blk, 4);
    chk("R7 pass fwd_erase", fwd_erase, 0);
    @(posedge clk); #1; fwd_ready = 0;
    @(negedge clk);
    chk("R7 backpressure ready", req_ready, 0);

    // R8 temporary override
    @(posedge clk); #1; fwd_ready = 1; temp_unlock = 1; req_blk = 5;
    @(negedge clk);
    chk("R8 override forwards", fwd_valid, 1);
    req_valid = 0;
    query(5, 8'h01);  // R8 stored flag still reported
    @(posedge clk); #1; temp_unlock = 0; req_valid = 1; req_blk = 5;
    @(negedge clk);
    chk("R8 restored drop", fwd_valid, 0);
    @(posedge clk); #1; req_valid = 0;

    // R2 back-pressure on status
    @(posedge clk); #1; stat_ready = 0;
    query(5, 8'h01);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 hold valid", stat_valid, 1);
      chk("R2 hold data", stat_data, 8'h01);
      chk("R2 vfy_ready low", vfy_ready, 0);
    end
    @(posedge clk); #1; stat_ready = 1;
    drain();

    // R4 protect every block, then timed unprotect
    for (int b = 0; b < 128; b++) strobe(1, 0, b);
    query(77, 8'h01);
    @(posedge clk); #1;
    mode_unprot = 1; wr_n = 0; req_valid = 1; req_blk = 4;
    begin
      int cnt = 0;
      @(negedge clk);
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (busy) cnt++;
        if (i == 3) begin
          chk("R6 ready low while busy", req_ready, 0);
          chk("R6 no forward while busy", fwd_valid, 0);
          wr_n = 1;
        end
        if (i == 5) wr_n = 0;   // R6 second strobe ignored
        if (!busy && cnt > 0) break;
      end
      chk("R4 busy length", cnt, DCYC);
    end
    wr_n = 1; mode_unprot = 0; req_valid = 0;
    query(0, 8'h00);
    query(77, 8'h00);
    query(127, 8'h00);
    drain();
    chk("R2 queue empty", exp_q.size(), 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule